// File: doc/BRIEF.md
# Ethernet Destination Address Filter with Multicast Hash

This block decides, for each received frame, whether the frame is kept. It looks only at the 48-bit destination address. It holds the station address, a 64-bit multicast hash table and four enable flags. All of these are loaded through a small write port, one 32-bit register per write. When an address is presented with a one-cycle strobe, the block returns an accept bit and a reason code one clock later. It also returns the 6-bit hash index it computed for that address, so that software can check its own hash tables.

The multicast hash is not CRC based. It is an XOR fold of shifted copies of the six address bytes, cut to six bits. The address bus carries byte 0, the first byte on the wire, in `da[47:40]`, and byte 5 in `da[7:0]`.

Register select codes on `cfg_sel`:
- 0: control word. Bit 0 enables unicast, bit 5 enables multicast, bit 13 enables broadcast and bit 21 enables promiscuous reception.
- 1: station address bytes 0 to 3.
- 2: station address byte 4.
- 3: station address byte 5.
- 4: low hash word.
- 5: high hash word.

Top module: `mcast_hash_filter`

## Requirements
- R1: The hash index is XOR of (b0>>2), (b0<<4), (b1>>4), (b1<<2), (b2>>6), b2, (b3>>2), (b3<<4), (b4>>4), (b4<<2), (b5>>6) and b5, cut to its low 6 bits. Here b0 is `da[47:40]` and b5 is `da[7:0]`. The index is presented on `res_hash_idx`.
- R2: Index values 0..31 select that bit of the low hash word (select 4). Index values 32..63 select bit (index-32) of the high hash word (select 5). A multicast address is accepted with reason 2 when the selected bit is 1 and control bit 5 is set.
- R3: When both hash words hold all ones and control bit 5 is set, every multicast address is accepted.
- R4: The station address is stored as follows. Select 1 holds bytes 0..3, with byte 0 in bits 7:0 and byte 3 in bits 31:24. Select 2 holds byte 4 in bits 7:0. Select 3 holds byte 5 in bits 7:0. A unicast address is accepted with reason 0 only when it matches all 48 bits and control bit 0 is set.
- R5: The all-ones address is broadcast. It is accepted with reason 1 when control bit 13 is set. It is never judged by the hash table, even when the table holds all ones.
- R6: An address other than all ones is multicast when bit 0 of byte 0 (`da[40]`) is 1. A multicast address is never accepted by a station match.
- R7: Control bit 21 (promiscuous) accepts every frame. The reason is 3 only when no other rule accepts the frame; otherwise the other rule's reason is given.
- R8: Reason codes are 0 unicast, 1 broadcast, 2 multicast and 3 promiscuous. A rejected result carries reason 0.
- R9: `res_valid` is high exactly in the cycle after `da_valid`. The result outputs change only on a strobed address and hold their values otherwise.
- R10: After reset, all configuration is zero, `res_valid` and `res_accept` are low and every address is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 47:40 |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_accept | output | 1 | Frame accepted |
| res_reason | output | 2 | Reason code |
| res_hash_idx | output | 6 | Computed hash index |

## Verification
Checked on every cycle:
- the one-cycle result timing and the holding of results between strobes;
- that a reject always carries reason 0;
- that promiscuous mode always accepts;
- that broadcast and multicast reasons appear only for addresses of that class.

Only the bench scenarios can show the following:
- that the hash fold and word/bit selection match the formula;
- that the station bytes sit in the right register lanes;
- that the enables gate each class;
- that broadcast takes priority over an all-ones hash table.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int AW = 48,
  parameter int HW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          da_valid,
  input  logic [AW-1:0] da,
  output logic          res_valid,
  output logic          res_accept,
  output logic [1:0]    res_reason,
  output logic [HW-1:0] res_hash_idx
);
  localparam int TBITS = 1 << HW;
  localparam logic [1:0] RS_UC = 2'd0, RS_BC = 2'd1, RS_MC = 2'd2, RS_PR = 2'd3;

  logic          en_uc, en_mc, en_bc, en_pr;
  logic [AW-1:0] station;
  logic [TBITS-1:0] htab;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {en_uc, en_mc, en_bc, en_pr} <= '0;
      station <= '0;
      htab    <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: begin
          en_uc <= cfg_wdata[0];
          en_mc <= cfg_wdata[5];
          en_bc <= cfg_wdata[13];
          en_pr <= cfg_wdata[21];
        end
        3'd1: station[47:16] <= {cfg_wdata[7:0], cfg_wdata[15:8], cfg_wdata[23:16], cfg_wdata[31:24]};
        3'd2: station[15:8]  <= cfg_wdata[7:0];
        3'd3: station[7:0]   <= cfg_wdata[7:0];
        3'd4: htab[31:0]     <= cfg_wdata;
        3'd5: htab[63:32]    <= cfg_wdata;
        default: ;
      endcase
    end
  end

  function automatic logic [5:0] fold(input logic [47:0] a);
    logic [7:0] b0, b1, b2, b3, b4, b5;
    {b0, b1, b2, b3, b4, b5} = a;
    return b0[7:2] ^ {b0[1:0], 4'b0} ^ {2'b0, b1[7:4]} ^ {b1[3:0], 2'b0}
         ^ {4'b0, b2[7:6]} ^ b2[5:0]
         ^ b3[7:2] ^ {b3[1:0], 4'b0} ^ {2'b0, b4[7:4]} ^ {b4[3:0], 2'b0}
         ^ {4'b0, b5[7:6]} ^ b5[5:0];
  endfunction

  logic [HW-1:0] hidx;
  logic is_bc, is_mc, hit_uc, hit_bc, hit_mc, acc;
  logic [1:0] why;

  assign hidx   = fold(da);
  assign is_bc  = &da;
  assign is_mc  = da[40] && !is_bc;
  assign hit_bc = is_bc && en_bc;
  assign hit_mc = is_mc && en_mc && htab[hidx];
  assign hit_uc = !da[40] && en_uc && (da == station);
  assign acc    = hit_bc || hit_mc || hit_uc || en_pr;

  always_comb begin
    if (hit_bc)      why = RS_BC;
    else if (hit_mc) why = RS_MC;
    else if (hit_uc) why = RS_UC;
    else if (en_pr)  why = RS_PR;
    else             why = RS_UC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_accept   <= 1'b0;
      res_reason   <= RS_UC;
      res_hash_idx <= '0;
    end else begin
      res_valid <= da_valid;
      if (da_valid) begin
        res_accept   <= acc;
        res_reason   <= why;
        res_hash_idx <= hidx;
      end
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> res_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> !res_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> $stable(res_accept) && $stable(res_reason) && $stable(res_hash_idx));
  a_r8_reject_reason: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_accept |-> res_reason == RS_UC);
  a_r7_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid && en_pr |=> res_accept);
  a_r5_bcast_class: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> !(res_accept && res_reason == RS_BC) || $past(&da));
  a_r6_mcast_class: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> !(res_accept && res_reason == RS_MC) || ($past(da[40]) && !$past(&da)));
endmodule

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic da_valid = 1'b0;
  logic [47:0] da = '0;
  logic res_valid, res_accept;
  logic [1:0] res_reason;
  logic [5:0] res_hash_idx;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  mcast_hash_filter dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da), .res_valid(res_valid),
    .res_accept(res_accept), .res_reason(res_reason), .res_hash_idx(res_hash_idx));

  typedef struct packed {
    logic [31:0] ctrl;
    logic [47:0] addr;
    logic        acc;
    logic [1:0]  why;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_2021, 48'h0011_2233_4455, 1'b1, 2'd0},
    '{32'h0000_2021, 48'h0011_2233_4456, 1'b0, 2'd0},
    '{32'h0000_2021, 48'hFFFF_FFFF_FFFF, 1'b1, 2'd1},
    '{32'h0000_2021, 48'h0100_5E00_0001, 1'b1, 2'd2},
    '{32'h0000_2021, 48'h0100_5E00_0002, 1'b0, 2'd0},
    '{32'h0000_2021, 48'h3333_0000_0001, 1'b1, 2'd2},
    '{32'h0000_0021, 48'hFFFF_FFFF_FFFF, 1'b0, 2'd0},
    '{32'h0000_2001, 48'h0100_5E00_0001, 1'b0, 2'd0},
    '{32'h0000_2020, 48'h0011_2233_4455, 1'b0, 2'd0},
    '{32'h0020_2021, 48'h00AA_BBCC_DDEE, 1'b1, 2'd3},
    '{32'h0020_2021, 48'h0011_2233_4455, 1'b1, 2'd0},
    '{32'h0020_2021, 48'h0100_5E00_0002, 1'b1, 2'd3}
  };

  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [7:0] b [6];
    logic [7:0] x;
    for (int i = 0; i < 6; i++) b[i] = a[47-8*i -: 8];
    x = (b[0] >> 2) ^ (b[0] << 4) ^ (b[1] >> 4) ^ (b[1] << 2) ^ (b[2] >> 6) ^ b[2]
      ^ (b[3] >> 2) ^ (b[3] << 4) ^ (b[4] >> 4) ^ (b[4] << 2) ^ (b[5] >> 6) ^ b[5];
    return x[5:0];
  endfunction

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic probe(input logic [47:0] a, input logic acc, input logic [1:0] why, input string req);
    @(negedge clk); da = a; da_valid = 1'b1;
    @(negedge clk); da_valid = 1'b0;
    chk({req, " valid"}, {31'b0, res_valid}, 32'd1);
    chk({req, " accept"}, {31'b0, res_accept}, {31'b0, acc});
    chk({req, " reason"}, {30'b0, res_reason}, {30'b0, why});
    chk("R1 hash index", {26'b0, res_hash_idx}, {26'b0, ref_hash(a)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid after reset", {31'b0, res_valid}, 32'd0);
    chk("R10 accept after reset", {31'b0, res_accept}, 32'd0);
    rst_n = 1'b1;
    probe(48'h0000_0000_0000, 1'b0, 2'd0, "R10 cleared config rejects");

    // R4 station lanes, R2 hash bits 14 (low word) and 50 (high word bit 18)
    wr(3'd1, 32'h3322_1100);
    wr(3'd2, 32'h0000_0044);
    wr(3'd3, 32'h0000_0055);
    wr(3'd4, 32'h0000_4000);
    wr(3'd5, 32'h0004_0000);
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, VECS[i].ctrl);
      probe(VECS[i].addr, VECS[i].acc, VECS[i].why, $sformatf("R2 R4 R5 R6 R7 R8 vec%0d", i));
    end

    // R6: multicast address equal to station must not match as unicast
    wr(3'd1, 32'h3322_1101);
    wr(3'd0, 32'h0000_0001);
    probe(48'h0111_2233_4455, 1'b0, 2'd0, "R6 mcast not station match");
    wr(3'd1, 32'h3322_1100);

    // R3: all-ones hash accepts any multicast
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd0, 32'h0000_0020);
    probe(48'h0100_5E00_0002, 1'b1, 2'd2, "R3 all-ones hash");
    probe(48'hABCD_EF01_2345, 1'b1, 2'd2, "R3 all-ones hash odd");
    probe(48'h0011_2233_4455, 1'b0, 2'd0, "R4 unicast disabled");
    // R5: broadcast not judged by hash
    probe(48'hFFFF_FFFF_FFFF, 1'b0, 2'd0, "R5 broadcast skips hash");

    // R9: hold between strobes, then back-to-back strobes
    repeat (3) @(negedge clk);
    chk("R9 valid idle", {31'b0, res_valid}, 32'd0);
    chk("R9 accept holds", {31'b0, res_accept}, 32'd0);
    @(negedge clk); da = 48'h0100_5E00_0001; da_valid = 1'b1;
    @(negedge clk); da = 48'h0000_0000_0001;
    chk("R9 b2b first", {31'b0, res_accept}, 32'd1);
    @(negedge clk); da_valid = 1'b0;
    chk("R9 b2b second", {31'b0, res_accept}, 32'd0);
    chk("R9 b2b valid", {31'b0, res_valid}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule